// File: doc/BRIEF.md
# CAN Nominal Bit Timer with Resynchronisation

This block divides the bus clock into time quanta and steps through the parts of each nominal CAN bit. A bit is one synchronisation quantum, then a first timing segment (propagation delay plus the positive phase buffer), then a second timing segment (the negative phase buffer). The block emits a one-clock strobe when each quantum ends. It emits a one-clock strobe, together with the sampled receive level, at the sample point between the two timing segments. It also emits a one-clock strobe on the first clock of every bit.

The receive input must already be synchronised to the clock. A falling (recessive-to-dominant) transition on it moves the bit grid. While the surrounding frame logic reports an idle bus, such an edge restarts the bit at once (hard synchronisation). Otherwise it lengthens the first segment or shortens the second one, limited by the jump width (resynchronisation).

The sampled bit is a plain strobe with no back-pressure. A consumer must take it in the cycle `sample_stb` is high. All settings are plain inputs. They are clamped to legal ranges and captured only at bit boundaries.

Top module: `can_bit_timer`

## Requirements
- R1: A quantum lasts exactly 2*(qdiv+1) clock cycles for every 8-bit qdiv from 0 to 255. `tq_tick` is high for exactly one clock at the end of each quantum, so with no edges a bit of N quanta holds exactly N ticks.
- R2: While reset is held, `bit_start` is high and `tq_tick` and `sample_stb` are low. The clock cycle in which reset is released is the first clock of a sync segment. With no edges, `bit_start` pulses once every (1+T1+T2) quanta.
- R3: `seg1_cfg` (4 bits) encodes T1-1. Codes 3 to 15 give T1 = 4 to 16 quanta, and codes 0 to 2 are treated as code 3.
- R4: `seg2_cfg` (3 bits) encodes T2-1. Codes 1 to 7 give T2 = 2 to 8 quanta, and code 0 is treated as code 1.
- R5: A bit is never shorter than 8 quanta. When T1=4 and T2=2, T1 is raised to 5.
- R6: `sample_stb` is a single-clock pulse. In a bit with no resynchronisation it rises (1+T1)*Q clocks after `bit_start`. `sample_bit` holds `rx_bit` as it was on the last clock of the first segment.
- R7: A resynchronising edge in first-segment quantum q (counted from 0) lengthens that segment by min(q+1, J) quanta.
- R8: A resynchronising edge in quantum q of a second segment of length L shortens that segment by min(L-1-q, J) quanta. An edge in the sync quantum changes nothing.
- R9: `sjw_cfg` (2 bits) encodes J-1, giving J = 1 to 4 quanta. J is limited to T2.
- R10: Only a 1-to-0 change of `rx_bit` counts as an edge. At most one resynchronisation is applied between two sample strobes, and later edges in that interval are ignored.
- R11: When `bus_idle` is high, an edge causes a hard synchronisation. `bit_start` pulses on the next clock and a full-length bit follows from there.
- R12: A change of `qdiv`, `seg1_cfg`, `seg2_cfg` or `sjw_cfg` takes effect at the next bit boundary. The bit in progress keeps its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_idle | input | 1 | High while the frame logic sees an idle bus; selects hard synchronisation |
| rx_bit | input | 1 | Synchronised receive line (1 = recessive) |
| qdiv | input | 8 | Quantum divider setting; quantum = 2*(qdiv+1) clocks |
| seg1_cfg | input | 4 | First timing segment length minus one |
| seg2_cfg | input | 3 | Second timing segment length minus one |
| sjw_cfg | input | 2 | Jump width minus one |
| tq_tick | output | 1 | One-clock pulse at the end of each quantum |
| sample_stb | output | 1 | One-clock pulse marking the sample point |
| sample_bit | output | 1 | Receive level captured at the sample point |
| bit_start | output | 1 | One-clock pulse on the first clock of every bit |

## Verification
The assertions assume that `rx_bit` comes from a synchroniser, so it changes at most once per clock. They also assume that an edge counts the same whether it lands in a quantum's first or last clock. They do not assume the settings are legal or stable: clamping and the boundary capture must keep the segment counters inside the limits the properties state. The stimulus changes inputs only on falling clock edges. It places every receive edge at a chosen clock offset from a bit start, so the quantum it lands in is known, and each resynchronisation case starts from a bit with no resynchronisation pending.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_TS1  = 2'd1,
    SEG_TS2  = 2'd2
  } seg_e;

  localparam int TS1_MIN_Q = 4;
  localparam int TS2_MIN_Q = 2;
  localparam int BIT_MIN_Q = 8;

endpackage

// File: rtl/cbt_cfg_hold.sv
module cbt_cfg_hold
  import cbt_pkg::*;
#(
  parameter int BRP_W = 8,
  parameter int TS1_W = 4,
  parameter int TS2_W = 3,
  parameter int SJW_W = 2,
  parameter int QW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BRP_W-1:0] div_in,
  input  logic [TS1_W-1:0] ts1_in,
  input  logic [TS2_W-1:0] ts2_in,
  input  logic [SJW_W-1:0] sjw_in,
  output logic [BRP_W-1:0] div_q,
  output logic [QW-1:0]    ts1_q,
  output logic [QW-1:0]    ts2_q,
  output logic [QW-1:0]    sjw_q
);

  localparam logic [QW-1:0] ONE_Q  = QW'(1);
  localparam logic [QW-1:0] T1_MIN = QW'(TS1_MIN_Q);
  localparam logic [QW-1:0] T2_MIN = QW'(TS2_MIN_Q);
  localparam logic [QW-1:0] B_MIN  = QW'(BIT_MIN_Q);

  logic [QW-1:0]    t1_raw, t2_raw, t1_fix, sj_raw, sj_fix;
  logic [BRP_W-1:0] div_hold;
  logic [QW-1:0]    ts1_hold, ts2_hold, sjw_hold;

  // clamp incoming settings to legal quanta counts
  always_comb begin
    t1_raw = QW'(ts1_in) + ONE_Q;
    if (t1_raw < T1_MIN) t1_raw = T1_MIN;
    t2_raw = QW'(ts2_in) + ONE_Q;
    if (t2_raw < T2_MIN) t2_raw = T2_MIN;
    t1_fix = t1_raw;
    if ((t1_raw + t2_raw + ONE_Q) < B_MIN) t1_fix = B_MIN - ONE_Q - t2_raw;
    sj_raw = QW'(sjw_in) + ONE_Q;
    sj_fix = (sj_raw > t2_raw) ? t2_raw : sj_raw;
  end

  // live inputs pass through only on a boundary clock
  always_comb begin
    if (load) begin
      div_q = div_in;
      ts1_q = t1_fix;
      ts2_q = t2_raw;
      sjw_q = sj_fix;
    end else begin
      div_q = div_hold;
      ts1_q = ts1_hold;
      ts2_q = ts2_hold;
      sjw_q = sjw_hold;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_hold <= '0;
      ts1_hold <= T1_MIN + ONE_Q;
      ts2_hold <= T2_MIN;
      sjw_hold <= ONE_Q;
    end else begin
      div_hold <= div_q;
      ts1_hold <= ts1_q;
      ts2_hold <= ts2_q;
      sjw_hold <= sjw_q;
    end
  end

  // R12
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (ts2_q == $past(ts2_q) || load));

endmodule

// File: rtl/cbt_quantum_div.sv
module cbt_quantum_div #(
  parameter int BRP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [BRP_W-1:0] div_val,
  output logic             tick
);

  localparam int CW = BRP_W + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last = {div_val, 1'b1};
  assign tick = (cnt >= last);

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (restart || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  // R1
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R11
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);

endmodule

// File: rtl/cbt_seg_fsm.sv
module cbt_seg_fsm
  import cbt_pkg::*;
#(
  parameter int QW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          edge_fall,
  input  logic          bus_idle,
  input  logic          rx_bit,
  input  logic [QW-1:0] ts1_q,
  input  logic [QW-1:0] ts2_q,
  input  logic [QW-1:0] sjw_q,
  output logic          hard_sync,
  output logic          sample_stb,
  output logic          sample_bit,
  output logic          bit_start
);

  localparam logic [QW-1:0] ONE_Q = QW'(1);

  seg_e          seg;
  logic [QW-1:0] qcnt, ts1_len, ts2_len;
  logic          rs_done;
  logic          late, early, resync;
  logic [QW-1:0] lag, ext, left, shr;
  logic [QW-1:0] len1_eff, len2_eff;
  logic          end_q1, end_q2;

  always_comb begin
    hard_sync = edge_fall && bus_idle;
    late      = edge_fall && !bus_idle && !rs_done && (seg == SEG_TS1);
    early     = edge_fall && !bus_idle && !rs_done && (seg == SEG_TS2);
    resync    = late || early;
    lag       = qcnt + ONE_Q;
    ext       = (lag < sjw_q) ? lag : sjw_q;
    left      = ts2_len - qcnt - ONE_Q;
    shr       = (left < sjw_q) ? left : sjw_q;
    len1_eff  = late  ? (ts1_len + ext) : ts1_len;
    len2_eff  = early ? (ts2_len - shr) : ts2_len;
    end_q1    = tick && (seg == SEG_TS1) && (qcnt == len1_eff - ONE_Q);
    end_q2    = tick && (seg == SEG_TS2) && (qcnt == len2_eff - ONE_Q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg        <= SEG_SYNC;
      qcnt       <= '0;
      ts1_len    <= ts1_q;
      ts2_len    <= ts2_q;
      rs_done    <= 1'b0;
      bit_start  <= 1'b1;
      sample_stb <= 1'b0;
      sample_bit <= 1'b1;
    end else if (hard_sync) begin
      seg        <= SEG_SYNC;
      qcnt       <= '0;
      rs_done    <= 1'b0;
      bit_start  <= 1'b1;
      sample_stb <= 1'b0;
    end else begin
      bit_start  <= end_q2;
      sample_stb <= end_q1;
      if (end_q1) sample_bit <= rx_bit;
      ts1_len <= len1_eff;
      ts2_len <= len2_eff;
      if (resync) rs_done <= 1'b1;
      if (end_q1) rs_done <= 1'b0;
      if (tick) begin
        unique case (seg)
          SEG_SYNC: begin
            seg     <= SEG_TS1;
            qcnt    <= '0;
            ts1_len <= ts1_q;
          end
          SEG_TS1: begin
            if (end_q1) begin
              seg     <= SEG_TS2;
              qcnt    <= '0;
              ts2_len <= ts2_q;
            end else begin
              qcnt <= qcnt + ONE_Q;
            end
          end
          default: begin
            if (end_q2) begin
              seg  <= SEG_SYNC;
              qcnt <= '0;
            end else begin
              qcnt <= qcnt + ONE_Q;
            end
          end
        endcase
      end
    end
  end

  // R2
  bnd_at_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_start |-> (seg == SEG_SYNC && qcnt == '0));

  // R6
  sample_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  // R7
  ts1_len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg == SEG_TS1) |-> (ts1_len >= ts1_q && ts1_len <= ts1_q + sjw_q && qcnt < ts1_len));

  // R8
  ts2_len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg == SEG_TS2) |-> (ts2_len <= ts2_q && ts2_len + sjw_q >= ts2_q && qcnt < ts2_len));

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int BRP_W = 8,
  parameter int TS1_W = 4,
  parameter int TS2_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_idle,
  input  logic             rx_bit,
  input  logic [BRP_W-1:0] qdiv,
  input  logic [TS1_W-1:0] seg1_cfg,
  input  logic [TS2_W-1:0] seg2_cfg,
  input  logic [SJW_W-1:0] sjw_cfg,
  output logic             tq_tick,
  output logic             sample_stb,
  output logic             sample_bit,
  output logic             bit_start
);

  localparam int QW = $clog2((2 ** TS1_W) + (2 ** TS2_W) + (2 ** SJW_W) + 2);

  logic             rx_prev;
  logic             edge_fall;
  logic             hard_sync;
  logic [BRP_W-1:0] div_q;
  logic [QW-1:0]    ts1_q, ts2_q, sjw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rx_prev <= 1'b1;
    else        rx_prev <= rx_bit;
  end

  assign edge_fall = rx_prev && !rx_bit;

  cbt_cfg_hold #(
    .BRP_W(BRP_W), .TS1_W(TS1_W), .TS2_W(TS2_W), .SJW_W(SJW_W), .QW(QW)
  ) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (bit_start),
    .div_in (qdiv),
    .ts1_in (seg1_cfg),
    .ts2_in (seg2_cfg),
    .sjw_in (sjw_cfg),
    .div_q  (div_q),
    .ts1_q  (ts1_q),
    .ts2_q  (ts2_q),
    .sjw_q  (sjw_q)
  );

  cbt_quantum_div #(.BRP_W(BRP_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (hard_sync),
    .div_val (div_q),
    .tick    (tq_tick)
  );

  cbt_seg_fsm #(.QW(QW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tq_tick),
    .edge_fall  (edge_fall),
    .bus_idle   (bus_idle),
    .rx_bit     (rx_bit),
    .ts1_q      (ts1_q),
    .ts2_q      (ts2_q),
    .sjw_q      (sjw_q),
    .hard_sync  (hard_sync),
    .sample_stb (sample_stb),
    .sample_bit (sample_bit),
    .bit_start  (bit_start)
  );

  // R6
  sample_vs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> !bit_start);

  // R11
  hard_sync_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_idle && rx_prev && !rx_bit) |=> bit_start);

endmodule

// File: tb/tb_can_bit_timer.sv
module tb_can_bit_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_idle = 1'b0;
  logic       rx_bit = 1'b1;
  logic [7:0] qdiv = 8'd0;
  logic [3:0] seg1_cfg = 4'd7;
  logic [2:0] seg2_cfg = 3'd3;
  logic [1:0] sjw_cfg = 2'd1;
  logic       tq_tick, sample_stb, sample_bit, bit_start;

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  can_bit_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_idle(bus_idle), .rx_bit(rx_bit),
    .qdiv(qdiv), .seg1_cfg(seg1_cfg), .seg2_cfg(seg2_cfg), .sjw_cfg(sjw_cfg),
    .tq_tick(tq_tick), .sample_stb(sample_stb), .sample_bit(sample_bit),
    .bit_start(bit_start)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic next_bs(output int c);
    do @(negedge clk); while (!bit_start);
    c = cyc;
  endtask

  // call on a bit_start negedge; measures the bit that begins there
  task automatic meas(output int len, output int nt, output int soff, output logic sb);
    int b0;
    b0 = cyc; nt = 0; soff = -1; sb = 1'b0;
    do begin
      @(negedge clk);
      if (tq_tick) nt++;
      if (sample_stb) begin soff = cyc - b0; sb = sample_bit; end
    end while (!bit_start);
    len = cyc - b0;
  endtask

  task automatic rs_case(input bit fresh, input int off, input int hold,
                         output int len, output int soff, output logic sb);
    int b;
    if (fresh) begin next_bs(b); next_bs(b); end
    else b = cyc;
    soff = -1; sb = 1'b1;
    while (cyc < b + off) @(negedge clk);
    rx_bit = 1'b0;
    do begin
      @(negedge clk);
      if (cyc == b + off + hold) rx_bit = 1'b1;
      if (sample_stb) begin soff = cyc - b; sb = sample_bit; end
    end while (!bit_start);
    len = cyc - b;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int b, c, len, nt, soff, t1, t2, nq, q;
    logic sb;

    // reset state (R1, R2, R6)
    repeat (3) @(negedge clk);
    chk("R2 bit_start in reset", int'(bit_start), 1);
    chk("R6 sample_stb in reset", int'(sample_stb), 0);
    chk("R1 tq_tick in reset", int'(tq_tick), 0);
    rst_n = 1'b1;
    b = cyc;
    next_bs(c);
    chk("R2 first bit after reset", c - b, 26);

    // sweep of divider and segment codes (R1 R3 R4 R5 R6)
    for (int d = 0; d < 2; d++) begin
      for (int s1 = 0; s1 < 16; s1++) begin
        for (int s2 = 0; s2 < 8; s2++) begin
          qdiv = 8'(d); seg1_cfg = 4'(s1); seg2_cfg = 3'(s2);
          next_bs(c);
          meas(len, nt, soff, sb);
          t1 = ((s1 < 3) ? 3 : s1) + 1;
          t2 = ((s2 < 1) ? 1 : s2) + 1;
          if (t1 + t2 < 7) t1 = 7 - t2;
          nq = 1 + t1 + t2;
          q = 2 * (d + 1);
          chk("R3 R4 R5 bit length", len, nq * q);
          chk("R1 ticks per bit", nt, nq);
          chk("R6 sample offset", soff, (1 + t1) * q);
          chk("R6 sample value", int'(sb), 1);
        end
      end
    end

    // largest divider (R1, R5)
    qdiv = 8'd255; seg1_cfg = 4'd3; seg2_cfg = 3'd1;
    next_bs(c);
    meas(len, nt, soff, sb);
    chk("R1 R5 max divider bit length", len, 8 * 512);

    // config change mid-bit (R12)
    qdiv = 8'd0; seg1_cfg = 4'd7; seg2_cfg = 3'd3; sjw_cfg = 2'd1;
    next_bs(b); next_bs(b);
    while (cyc < b + 5) @(negedge clk);
    qdiv = 8'd1; seg1_cfg = 4'd3; seg2_cfg = 3'd3;
    next_bs(c);
    chk("R12 current bit unchanged", c - b, 26);
    meas(len, nt, soff, sb);
    chk("R12 next bit uses new setting", len, 36);

    // resynchronisation: Q=2, T1=8, T2=4, J=2, nominal 26 clocks
    qdiv = 8'd0; seg1_cfg = 4'd7; seg2_cfg = 3'd3; sjw_cfg = 2'd1;
    rs_case(1'b1, 0, 26 + 5, len, soff, sb);
    chk("R8 edge in sync quantum", len, 26);
    b = cyc;
    while (cyc < b + 5) @(negedge clk);
    rx_bit = 1'b1;
    next_bs(c);
    chk("R10 rising edge ignored", c - b, 26);

    rs_case(1'b1, 2, 1, len, soff, sb);
    chk("R7 late edge q0", len, 28);
    rs_case(1'b1, 9, 40, len, soff, sb);
    chk("R7 late edge q3 limited by jump", len, 30);
    chk("R6 sample shifted by lengthening", soff, 22);
    chk("R6 sampled dominant", int'(sb), 0);
    rx_bit = 1'b1;
    rs_case(1'b1, 17, 1, len, soff, sb);
    chk("R7 late edge last clock of segment", len, 30);
    rs_case(1'b1, 18, 1, len, soff, sb);
    chk("R8 early edge q0", len, 22);
    rs_case(1'b0, 2, 1, len, soff, sb);
    chk("R10 edge before next sample blocked", len, 26);
    rs_case(1'b1, 22, 1, len, soff, sb);
    chk("R8 early edge q2", len, 24);
    rs_case(1'b1, 25, 1, len, soff, sb);
    chk("R8 early edge last quantum", len, 26);

    // two edges in one interval (R10)
    next_bs(b); next_bs(b);
    while (cyc < b + 2) @(negedge clk);
    rx_bit = 1'b0; @(negedge clk); rx_bit = 1'b1;
    while (cyc < b + 9) @(negedge clk);
    rx_bit = 1'b0; @(negedge clk); rx_bit = 1'b1;
    next_bs(c);
    chk("R10 second edge ignored", c - b, 28);

    // jump width 1 (R9)
    sjw_cfg = 2'd0;
    rs_case(1'b1, 18, 1, len, soff, sb);
    chk("R9 jump of one quantum", len, 24);

    // jump width clamped to T2 (R9)
    sjw_cfg = 2'd3; seg2_cfg = 3'd1;
    rs_case(1'b1, 9, 1, len, soff, sb);
    chk("R9 jump limited to seg2", len, 26);

    // hard synchronisation (R11)
    seg2_cfg = 3'd3; sjw_cfg = 2'd1; bus_idle = 1'b1;
    next_bs(b); next_bs(b);
    while (cyc < b + 7) @(negedge clk);
    rx_bit = 1'b0;
    next_bs(c);
    chk("R11 hard sync restart", c - b, 8);
    rx_bit = 1'b1;
    meas(len, nt, soff, sb);
    chk("R11 full bit after hard sync", len, 26);
    b = cyc;
    while (cyc < b + 23) @(negedge clk);
    rx_bit = 1'b0;
    next_bs(c);
    chk("R11 hard sync from seg2", c - b, 24);
    rx_bit = 1'b1;
    bus_idle = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule